// File: doc/BRIEF.md
# Write-Only Serial Configuration Slave

This block is the configuration port of a clock-generator device. It watches a two-wire serial bus made of a clock line and a data line, in the style of I2C, and accepts one fixed kind of transfer: a block write of eleven bytes. The first byte is the device address with the write direction bit. The next two bytes are framing bytes (a command code and a byte count), which are counted but whose values are discarded. The last eight bytes are data. Data byte k always lands in configuration register k.

A fast system clock oversamples both bus lines through two-flop synchronizers and finds START, STOP and clock edges in the sampled stream. The slave never returns data. Its only drive onto the bus is an acknowledge, which is modelled as a pull-low enable for an open-drain data pad. Every register loads a default at reset, so the device works without any serial write.

The eight registers are presented side by side as plain level outputs for clock enables and mode selects. No data stream crosses the block's edge, so there is no valid/ready pair and no back-pressure. The outputs change only when a data byte is committed.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset the register outputs hold their defaults: register 0 = 8'h00, registers 1 to 6 = 8'hFF, register 7 = 8'h0F (register k occupies `cfg_o[8k+7:8k]`).
- R2: A START is a falling data line while the clock line is high. A STOP is a rising data line while the clock line is high. A START at any point, including during a frame or after a rejected address, begins a new frame at the address byte.
- R3: Bits are taken on the rising bus clock edge, most significant bit first. The first byte of a frame must equal 8'hD2. Any other value, including 8'hD3, gets no acknowledge and leaves every register unchanged for the rest of that frame.
- R4: In a frame whose address matched, the slave pulls the data line low during the ninth clock of each of the eleven bytes. It does not pull the line at any other time.
- R5: The second and third bytes of a frame are acknowledged and counted, and their values have no effect on any register.
- R6: Data byte k (k = 0..7, the byte in frame position k+3) is written to register k. The write happens only when the clock falls at the end of that byte's acknowledge clock.
- R7: A STOP or repeated START in the middle of a frame keeps the bytes already committed. A byte whose eight bits or acknowledge did not complete is discarded.
- R8: Reserved bits read as 0 whatever value is written to them. The reserved bits are register 0 bits 7:6 and register 7 bits 7:4.
- R9: Bytes after the eleventh byte of a frame get no acknowledge and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial bus clock line as seen at the pad |
| sda_i | input | 1 | Serial bus data line as seen at the pad (wired-AND value) |
| sda_pull_o | output | 1 | Enable to pull the data line low for an acknowledge |
| cfg_o | output | 64 | Configuration registers; register k at bits 8k+7:8k |

## Verification
The hardest cases to reach are the frame endings that fall between byte boundaries. These are a STOP or repeated START after a few bits of a data byte, and a frame that keeps clocking past its eleventh byte. In both cases the question is which bytes were committed and which were dropped. The bench drives the bus one bit at a time, so it can stop a byte after any number of bits and then raise a repeated START or a STOP. It then checks the register outputs against a model that holds only the bytes whose acknowledge completed. Rejected addresses, including the read variant, are followed straight away by a valid frame. This shows that the slave stays quiet for the rest of the bad frame and recovers on the next START.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;
  localparam int REG_W       = 8;
  localparam int NREG        = 8;
  localparam int HDR_BYTES   = 3;
  localparam int FRAME_BYTES = HDR_BYTES + NREG;
  localparam int CFG_W       = NREG * REG_W;
  localparam logic [7:0] DEV_ADDR = 8'hD2;

  // Register k lives at bits [8k+7:8k]
  localparam logic [CFG_W-1:0] CFG_DEFAULT = 64'h0FFF_FFFF_FFFF_FF00;
  localparam logic [CFG_W-1:0] CFG_RSVD    = 64'hF000_0000_0000_00C0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BITS,
    ST_WFALL,
    ST_ACK,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/cfg_bus_sync.sv
module cfg_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;
  localparam int DEPTH = STAGES + 1;

  logic [LINES-1:0] line_in;
  logic [LINES-1:0] lvl, prev;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [DEPTH-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[DEPTH-2:0], line_in[g]};
    end
    assign lvl[g]  = pipe[STAGES-1];
    assign prev[g] = pipe[STAGES];
  end

  assign scl_lvl   = lvl[0];
  assign sda_lvl   = lvl[1];
  assign scl_rise  = lvl[0] & ~prev[0];
  assign scl_fall  = ~lvl[0] & prev[0];
  assign start_det = lvl[0] & prev[0] & prev[1] & ~lvl[1];
  assign stop_det  = lvl[0] & prev[0] & ~prev[1] & lvl[1];
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
  import cfg_slave_pkg::*;
#(
  parameter logic [7:0] ADDR   = DEV_ADDR,
  parameter int         NBYTES = FRAME_BYTES,
  parameter int         HDR    = HDR_BYTES,
  parameter int         NR     = NREG
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_lvl,
  input  logic                  sda_lvl,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  start_det,
  input  logic                  stop_det,
  output logic                  sda_pull,
  output logic                  wr_en,
  output logic [$clog2(NR)-1:0] wr_idx,
  output logic [7:0]            wr_data
);
  localparam int BW = $clog2(NBYTES + 1);
  localparam int IW = $clog2(NR);

  rx_state_e      state;
  logic [2:0]     bit_cnt;
  logic [BW-1:0]  byte_idx;
  logic [7:0]     shreg;
  logic [7:0]     shift_nxt;
  logic [BW-1:0]  rel_idx;

  assign shift_nxt = {shreg[6:0], sda_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      byte_idx <= '0;
      shreg    <= '0;
    end else if (start_det) begin
      state    <= ST_BITS;
      bit_cnt  <= '0;
      byte_idx <= '0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
    end else begin
      case (state)
        ST_BITS: if (scl_rise) begin
          shreg <= shift_nxt;
          if (bit_cnt == 3'd7) begin
            bit_cnt <= '0;
            if (byte_idx == '0 && shift_nxt != ADDR) state <= ST_SKIP;
            else                                     state <= ST_WFALL;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
          end
        end
        ST_WFALL: if (scl_fall) state <= ST_ACK;
        ST_ACK: if (scl_fall) begin
          byte_idx <= byte_idx + 1'b1;
          state    <= (byte_idx == BW'(NBYTES - 1)) ? ST_SKIP : ST_BITS;
        end
        default: state <= state;
      endcase
    end
  end

  assign sda_pull = (state == ST_ACK);
  assign rel_idx  = byte_idx - BW'(HDR);
  assign wr_en    = (state == ST_ACK) && scl_fall && !start_det && !stop_det
                    && (byte_idx >= BW'(HDR));
  assign wr_idx   = rel_idx[IW-1:0];
  assign wr_data  = shreg;

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_BITS && byte_idx == '0 && bit_cnt == '0));

  // R4
  ack_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_lvl);

  // R6
  commit_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(sda_pull));

  // R7
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_pull && !wr_en));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_slave_pkg::*;
#(
  parameter int                       NR   = NREG,
  parameter logic [NR*REG_W-1:0]      DEFV = CFG_DEFAULT,
  parameter logic [NR*REG_W-1:0]      RSVD = CFG_RSVD
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [$clog2(NR)-1:0] wr_idx,
  input  logic [REG_W-1:0]      wr_data,
  output logic [NR*REG_W-1:0]   cfg
);
  for (genvar k = 0; k < NR; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg[k*REG_W +: REG_W] <= DEFV[k*REG_W +: REG_W] & ~RSVD[k*REG_W +: REG_W];
      else if (wr_en && wr_idx == ($clog2(NR))'(k))
        cfg[k*REG_W +: REG_W] <= wr_data & ~RSVD[k*REG_W +: REG_W];
    end
  end

  // R8
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg & RSVD) == '0);

  // R6
  hold_unless_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(cfg));
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfg_slave_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  output logic [CFG_W-1:0] cfg_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [$clog2(NREG)-1:0] wr_idx;
  logic [REG_W-1:0] wr_data;

  cfg_bus_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  cfg_frame_rx #(.ADDR(DEV_ADDR), .NBYTES(FRAME_BYTES), .HDR(HDR_BYTES), .NR(NREG)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_pull(sda_pull_o), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfg_regs #(.NR(NREG), .DEFV(CFG_DEFAULT), .RSVD(CFG_RSVD)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .cfg(cfg_o)
  );
endmodule

// File: tb/test_cfg_serial_slave.sv
`timescale 1ns/1ps
module test_cfg_serial_slave;
  localparam logic [63:0] DEF_V  = 64'h0FFF_FFFF_FFFF_FF00;
  localparam logic [63:0] RSVD_V = 64'hF000_0000_0000_00C0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [63:0] cfg;
  wire  sda_bus = sda_m & ~sda_pull;

  int checks = 0;
  int fails = 0;
  logic [63:0] model;
  logic [63:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  cfg_serial_slave i_cfg_serial_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .cfg_o(cfg)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void put(input int k, input logic [7:0] v);
    model[8*k +: 8] = v & ~RSVD_V[8*k +: 8];
  endfunction

  task automatic expect_cfg(input string tag);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  task automatic clk_bit(input logic b);
    scl_m = 1'b0; tick(5); sda_m = b; tick(5);
    scl_m = 1'b1; tick(10); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    tick(5); sda_m = 1'b1; tick(5);
    scl_m = 1'b1; tick(5);
    chk(sda_bus == !exp_ack, req, {63'd0, sda_bus}, {63'd0, !exp_ack});
    tick(5); scl_m = 1'b0;
  endtask

  task automatic do_start();
    sda_m = 1'b1; tick(3); scl_m = 1'b1; tick(6);
    sda_m = 1'b0; tick(6); scl_m = 1'b0; tick(2);
  endtask

  task automatic do_stop();
    scl_m = 1'b0; tick(3); sda_m = 1'b0; tick(4);
    scl_m = 1'b1; tick(6); sda_m = 1'b1; tick(10);
  endtask

  task automatic good_frame(input logic [7:0] c0, input logic [7:0] c1,
                            input logic [63:0] d, input string req);
    do_start();
    send_byte(8'hD2, 1'b1, "R3");
    send_byte(c0, 1'b1, "R5");
    send_byte(c1, 1'b1, "R5");
    for (int k = 0; k < 8; k++) begin
      send_byte(d[8*k +: 8], 1'b1, "R4");
      put(k, d[8*k +: 8]);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) tick(1);
    tick(4);
  endtask

  // Monitor: compares register outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [63:0] e;
        string t;
        tick(2);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(cfg == e, t, cfg, e);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    model = DEF_V;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R1 reset defaults
    chk(cfg == DEF_V, "R1", cfg, DEF_V);

    // R4 R6 R8: full frame, reserved bits written as ones
    good_frame(8'h00, 8'h08, 64'hFFC3_3C80_015A_A5FF, "R6");
    do_stop(); tick(10);
    expect_cfg("R8"); drain();

    // R3: wrong address, then the read variant; nothing acknowledged or written
    do_start();
    send_byte(8'hD0, 1'b0, "R3");
    for (int k = 0; k < 10; k++) send_byte(8'h00, 1'b0, "R3");
    do_start();
    send_byte(8'hD3, 1'b0, "R3");
    send_byte(8'h11, 1'b0, "R3");
    do_stop(); tick(10);
    expect_cfg("R3"); drain();

    // R2 R5: START after a rejected frame; framing byte values ignored
    good_frame(8'hFF, 8'h55, 64'h1716_1514_1312_1110, "R5");
    do_stop(); tick(10);
    expect_cfg("R5"); drain();

    // R7: STOP after four bits of data byte 2
    do_start();
    send_byte(8'hD2, 1'b1, "R7");
    send_byte(8'h01, 1'b1, "R7");
    send_byte(8'h02, 1'b1, "R7");
    send_byte(8'h77, 1'b1, "R7"); put(0, 8'h77);
    send_byte(8'h66, 1'b1, "R7"); put(1, 8'h66);
    for (int i = 0; i < 4; i++) clk_bit(1'b0);
    do_stop(); tick(10);
    expect_cfg("R7"); drain();

    // R2 R7: repeated START after three bits of data byte 1
    do_start();
    send_byte(8'hD2, 1'b1, "R2");
    send_byte(8'h00, 1'b1, "R2");
    send_byte(8'h00, 1'b1, "R2");
    send_byte(8'h12, 1'b1, "R2"); put(0, 8'h12);
    for (int i = 0; i < 3; i++) clk_bit(1'b1);
    do_start();
    send_byte(8'hD2, 1'b1, "R2");
    send_byte(8'h00, 1'b1, "R2");
    send_byte(8'h00, 1'b1, "R2");
    send_byte(8'h9A, 1'b1, "R2"); put(0, 8'h9A);
    do_stop(); tick(10);
    expect_cfg("R7"); drain();

    // R9: extra bytes after the eleventh get no acknowledge and no effect
    good_frame(8'h00, 8'h08, 64'h0807_0605_0403_0201, "R9");
    send_byte(8'hEE, 1'b0, "R9");
    send_byte(8'hEE, 1'b0, "R9");
    do_stop(); tick(10);
    expect_cfg("R9"); drain();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule